// File: doc/BRIEF.md
# Buffered NOR Flash Programming Sequencer

This block programs a 16-bit parallel NOR flash from a byte stream. A start pulse loads a word address and a byte length. The block then takes the bytes over a valid/ready handshake and turns them into 16-bit words. It writes them to the flash one chunk at a time, using the flash's buffered-program command sequence. Each chunk holds at most `CHUNK_WORDS` words and never crosses an erase block boundary.

For each chunk the block runs these steps:
- It clears the status register.
- It sends the buffer setup and word-count commands to the block base.
- It writes the data words.
- It confirms the buffer.
- It polls the status register until the device reports ready.

After the last chunk the block sets the array back to normal reads and pulses `done_o`. An error bit in the status word stops the job and raises `error_o` instead.

Every bus access is a fixed window of `CYC` clocks. Chip enable and address-valid are held low for the whole window. Write enable goes low only inside an inner window set by a down-counter. At least one idle clock separates two accesses.

Top module: `nor_bufprog_seq`

## Requirements
- R1: After reset, chip enable, write enable, output enable and address-valid are all high. The data bus is not driven, `s_ready_o` is low, and `done_o` and `error_o` are low.
- R2: Each chunk is issued as this exact series of writes: 0x0050 to word address 0, 0x00E9 to the block base, the chunk's word count minus one to the block base, the data words, then 0x00D0 to the block base. The block base is the chunk address with its low log2(`BLOCK_WORDS`) bits cleared.
- R3: The chunk length is the smallest of three values: `CHUNK_WORDS`, the words still to program, and the words left up to the end of the current block. Data words go to consecutive word addresses, starting at the job's start address.
- R4: A data word holds two stream bytes, each with its bit order reversed. The earlier byte goes in bits 15:8 and the later byte in bits 7:0.
- R5: When the byte length is odd, the low half of the final word is 0xFF.
- R6: A write access keeps chip enable and address-valid low and drives the data bus for exactly `CYC` clocks, with the address and data held steady. Write enable is low only while the down-counter (`CYC`-1 down to 0) is above `WE_LO` and below `WE_HI`. With the defaults that is 9 clocks, starting at the 6th clock of the access.
- R7: A status read keeps output enable low for `CYC` clocks with the data bus released and write enable high. The block samples the status at down-counter value `RD_SAMPLE`.
- R8: After the confirm write, the block reads the status at the block base again and again. It moves on only once bit 7 (ready) reads as 1.
- R9: If bit 7 is set and any of bits 5:1 is set, the job stops. `error_o` stays high until the next start, no further write occurs, and `done_o` does not pulse.
- R10: After the last chunk the block writes 0x00FF to word address 0. It then pulses `done_o` for exactly one clock.
- R11: A job with byte length 0 performs only the 0x00FF write and then pulses `done_o`.
- R12: Chip enable returns high for at least one clock between two accesses.
- R13: Exactly the job's byte length is accepted from the stream. `s_ready_o` is low outside the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a job (sampled when idle) |
| base_addr_i | input | ADDR_W | First word address to program |
| byte_len_i | input | LEN_W | Number of bytes in the job |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Stream byte accepted when high with valid |
| flash_addr_o | output | ADDR_W | Flash word address |
| flash_dq_o | output | 16 | Flash write data |
| flash_dq_oe_o | output | 1 | Drive enable for the data bus |
| flash_dq_i | input | 16 | Flash read data |
| flash_ce_n_o | output | 1 | Chip enable, active low |
| flash_we_n_o | output | 1 | Write enable, active low |
| flash_oe_n_o | output | 1 | Output enable, active low |
| flash_adv_n_o | output | 1 | Address valid, active low |
| done_o | output | 1 | One-clock pulse at job completion |
| error_o | output | 1 | Job stopped on a status error |

## Verification
The bench builds the block with `CHUNK_WORDS` = 8 and `BLOCK_WORDS` = 16, and keeps the 20-clock access window. With these values, short random jobs at unaligned start addresses reach every case within a few hundred bytes: chunks cut at a block end, several chunks per job, and chunks cut by the end of the data. The full access timing is still checked at its real length. A flash model returns "busy" for a chosen number of polls. It puts junk in the status bits that do not matter, and returns a misleading value early in each read window, so a wrong sample point is caught.

// File: rtl/nbp_pkg.sv
// Shared command codes, state encoding and helper functions for the
// buffered NOR programming sequencer.
package nbp_pkg;

    localparam logic [15:0] CMD_CLR_STATUS  = 16'h0050;
    localparam logic [15:0] CMD_BUF_SETUP   = 16'h00E9;
    localparam logic [15:0] CMD_BUF_CONFIRM = 16'h00D0;
    localparam logic [15:0] CMD_READ_ARRAY  = 16'h00FF;

    localparam logic [15:0] ST_READY_MASK = 16'h0080;
    localparam logic [15:0] ST_ERR_MASK   = 16'h003E;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_PLAN,
        SQ_CLR,
        SQ_SETUP,
        SQ_COUNT,
        SQ_DATA,
        SQ_CONFIRM,
        SQ_POLL,
        SQ_CHECK,
        SQ_RDARR,
        SQ_FIN
    } sq_state_t;

    // Mirror the bit order of one byte.
    function automatic logic [7:0] bit_rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

endpackage

// File: rtl/nbp_bus_cycle.sv
// One flash bus access of a fixed CYC-clock window.
// Assumes: start_i is only honoured while idle; the caller holds read_i,
// addr_i and data_i valid in the cycle it raises start_i.
// A down-counter runs CYC-1..0; write enable is low strictly between
// WE_LO and WE_HI, and read data is captured at RD_SAMPLE.
module nbp_bus_cycle #(
    parameter int ADDR_W    = 25,
    parameter int CYC       = 20,
    parameter int WE_LO     = 5,
    parameter int WE_HI     = 15,
    parameter int RD_SAMPLE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              read_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [15:0]       rdata_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [15:0]       dq_o,
    output logic              dq_oe_o,
    input  logic [15:0]       dq_i,
    output logic              ce_n_o,
    output logic              we_n_o,
    output logic              oe_n_o,
    output logic              adv_n_o
);
    localparam int CW = $clog2(CYC);

    logic [CW-1:0]     cnt;
    logic              busy;
    logic              rd;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       data_q;
    logic [15:0]       rdata_q;

    // Window counter and latched access attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            rd     <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (!busy && start_i) begin
            busy   <= 1'b1;
            cnt    <= CW'(CYC - 1);
            rd     <= read_i;
            addr_q <= addr_i;
            data_q <= data_i;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // Capture of the read data near the end of the read window.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         rdata_q <= '0;
        else if (busy && rd && int'(cnt) == RD_SAMPLE)      rdata_q <= dq_i;
    end

    // Bus pin decode from the window state.
    always_comb begin
        busy_o  = busy;
        done_o  = busy && (cnt == '0);
        rdata_o = rdata_q;
        addr_o  = addr_q;
        dq_o    = data_q;
        dq_oe_o = busy && !rd;
        ce_n_o  = !busy;
        adv_n_o = !busy;
        oe_n_o  = !(busy && rd);
        we_n_o  = !(busy && !rd && int'(cnt) > WE_LO && int'(cnt) < WE_HI);
    end

endmodule

// File: rtl/nbp_chunk_plan.sv
// Sizes the next chunk: the least of the chunk limit, the remaining
// words and the words left up to the end of the erase block.
// Assumes BLOCK_WORDS is a power of two.
module nbp_chunk_plan #(
    parameter int ADDR_W      = 25,
    parameter int WC_W        = 24,
    parameter int BLOCK_WORDS = 131072,
    parameter int CHUNK_WORDS = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WC_W-1:0]   rem_i,
    output logic [$clog2(CHUNK_WORDS+1)-1:0] n_o,
    output logic [ADDR_W-1:0] blk_o
);
    localparam int BOFF_W = $clog2(BLOCK_WORDS);
    localparam int NW     = $clog2(CHUNK_WORDS + 1);

    logic [BOFF_W:0] to_end;
    logic [31:0]     lim;

    // Block base and distance to the block end.
    always_comb begin
        blk_o  = {addr_i[ADDR_W-1:BOFF_W], BOFF_W'(0)};
        to_end = (BOFF_W+1)'(BLOCK_WORDS) - {1'b0, addr_i[BOFF_W-1:0]};
    end

    // Minimum of the three limits.
    always_comb begin
        lim = 32'(CHUNK_WORDS);
        if (32'(to_end) < lim) lim = 32'(to_end);
        if (32'(rem_i)  < lim) lim = 32'(rem_i);
        n_o = NW'(lim);
    end

endmodule

// File: rtl/nbp_packer.sv
// Byte-to-word packer: mirrors each byte, places the earlier byte high,
// and closes a lone final byte with 0xFF when pad_i is set.
// Assumes fill_en_i is low whenever no further word is wanted.
module nbp_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush_i,
    input  logic        fill_en_i,
    input  logic        pad_i,
    input  logic [7:0]  s_data_i,
    input  logic        s_valid_i,
    output logic        s_ready_o,
    input  logic        take_i,
    output logic [15:0] word_o,
    output logic        word_vld_o
);
    import nbp_pkg::*;

    logic [7:0]  hi_q;
    logic        have_hi;
    logic [15:0] word_q;
    logic        word_vld;
    logic        hs;

    // Handshake decode.
    always_comb begin
        s_ready_o  = fill_en_i && !word_vld;
        hs         = s_valid_i && s_ready_o;
        word_o     = word_q;
        word_vld_o = word_vld;
    end

    // Byte collection and word assembly.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            hi_q     <= '0;
            have_hi  <= 1'b0;
            word_q   <= '0;
            word_vld <= 1'b0;
        end else begin
            if (take_i) word_vld <= 1'b0;
            if (hs) begin
                if (!have_hi) begin
                    if (pad_i) begin
                        word_q   <= {bit_rev8(s_data_i), 8'hFF};
                        word_vld <= 1'b1;
                    end else begin
                        hi_q    <= bit_rev8(s_data_i);
                        have_hi <= 1'b1;
                    end
                end else begin
                    word_q   <= {hi_q, bit_rev8(s_data_i)};
                    word_vld <= 1'b1;
                    have_hi  <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/nor_bufprog_seq.sv
// Top of the buffered NOR programming sequencer. It walks each chunk
// through clear-status, setup, count, data, confirm and status polling,
// then ends the job with a read-array write and a done pulse.
// Assumes one job at a time; start_i is ignored while a job runs.
module nor_bufprog_seq #(
    parameter int ADDR_W      = 25,
    parameter int LEN_W       = 24,
    parameter int CHUNK_WORDS = 32,
    parameter int BLOCK_WORDS = 131072,
    parameter int CYC         = 20,
    parameter int WE_LO       = 5,
    parameter int WE_HI       = 15,
    parameter int RD_SAMPLE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [LEN_W-1:0]  byte_len_i,
    input  logic [7:0]        s_data_i,
    input  logic              s_valid_i,
    output logic              s_ready_o,
    output logic [ADDR_W-1:0] flash_addr_o,
    output logic [15:0]       flash_dq_o,
    output logic              flash_dq_oe_o,
    input  logic [15:0]       flash_dq_i,
    output logic              flash_ce_n_o,
    output logic              flash_we_n_o,
    output logic              flash_oe_n_o,
    output logic              flash_adv_n_o,
    output logic              done_o,
    output logic              error_o
);
    import nbp_pkg::*;

    localparam int NW   = $clog2(CHUNK_WORDS + 1);
    localparam int WC_W = LEN_W;

    sq_state_t         state;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] blk_q;
    logic [WC_W-1:0]   pack_rem;
    logic [NW-1:0]     n_q;
    logic [NW-1:0]     ctake_left;
    logic [NW-1:0]     chunk_left;
    logic              len_odd;
    logic              err_q;

    logic              bc_want, bc_start, bc_read, bc_busy, bc_done;
    logic [ADDR_W-1:0] bc_addr;
    logic [15:0]       bc_data, bc_rdata;
    logic [NW-1:0]     plan_n;
    logic [ADDR_W-1:0] plan_blk;
    logic [15:0]       pk_word;
    logic              pk_vld, pk_take, pk_fill, pk_pad, pk_flush;
    logic              st_ready, st_err;

    nbp_chunk_plan #(
        .ADDR_W(ADDR_W), .WC_W(WC_W),
        .BLOCK_WORDS(BLOCK_WORDS), .CHUNK_WORDS(CHUNK_WORDS)
    ) u_plan (
        .addr_i(cur_addr), .rem_i(pack_rem), .n_o(plan_n), .blk_o(plan_blk)
    );

    nbp_packer u_pack (
        .clk(clk), .rst_n(rst_n), .flush_i(pk_flush), .fill_en_i(pk_fill),
        .pad_i(pk_pad), .s_data_i(s_data_i), .s_valid_i(s_valid_i),
        .s_ready_o(s_ready_o), .take_i(pk_take), .word_o(pk_word),
        .word_vld_o(pk_vld)
    );

    nbp_bus_cycle #(
        .ADDR_W(ADDR_W), .CYC(CYC), .WE_LO(WE_LO), .WE_HI(WE_HI),
        .RD_SAMPLE(RD_SAMPLE)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .start_i(bc_start), .read_i(bc_read),
        .addr_i(bc_addr), .data_i(bc_data), .busy_o(bc_busy),
        .done_o(bc_done), .rdata_o(bc_rdata), .addr_o(flash_addr_o),
        .dq_o(flash_dq_o), .dq_oe_o(flash_dq_oe_o), .dq_i(flash_dq_i),
        .ce_n_o(flash_ce_n_o), .we_n_o(flash_we_n_o),
        .oe_n_o(flash_oe_n_o), .adv_n_o(flash_adv_n_o)
    );

    // Access request for the current state.
    always_comb begin
        bc_want = 1'b0;
        bc_read = 1'b0;
        bc_addr = '0;
        bc_data = '0;
        case (state)
            SQ_CLR:     begin bc_want = 1'b1; bc_data = CMD_CLR_STATUS; end
            SQ_SETUP:   begin bc_want = 1'b1; bc_addr = blk_q; bc_data = CMD_BUF_SETUP; end
            SQ_COUNT:   begin bc_want = 1'b1; bc_addr = blk_q; bc_data = 16'(n_q) - 16'd1; end
            SQ_DATA:    begin bc_want = pk_vld; bc_addr = cur_addr; bc_data = pk_word; end
            SQ_CONFIRM: begin bc_want = 1'b1; bc_addr = blk_q; bc_data = CMD_BUF_CONFIRM; end
            SQ_POLL:    begin bc_want = 1'b1; bc_read = 1'b1; bc_addr = blk_q; end
            SQ_RDARR:   begin bc_want = 1'b1; bc_data = CMD_READ_ARRAY; end
            default:    ;
        endcase
        bc_start = bc_want && !bc_busy;
    end

    // Packer control and status decode.
    always_comb begin
        pk_take  = bc_start && (state == SQ_DATA);
        pk_fill  = (state == SQ_DATA) && (ctake_left != '0);
        pk_pad   = len_odd && (pack_rem == WC_W'(1));
        pk_flush = (state == SQ_IDLE) && start_i;
        st_ready = (bc_rdata & ST_READY_MASK) != '0;
        st_err   = (bc_rdata & ST_ERR_MASK) != '0;
        done_o   = (state == SQ_FIN);
        error_o  = err_q;
    end

    // Job sequencing over chunks and command steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            cur_addr   <= '0;
            blk_q      <= '0;
            pack_rem   <= '0;
            n_q        <= '0;
            ctake_left <= '0;
            chunk_left <= '0;
            len_odd    <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: if (start_i) begin
                    cur_addr <= base_addr_i;
                    pack_rem <= WC_W'(({1'b0, byte_len_i} + (LEN_W+1)'(1)) >> 1);
                    len_odd  <= byte_len_i[0];
                    err_q    <= 1'b0;
                    state    <= (byte_len_i == '0) ? SQ_RDARR : SQ_PLAN;
                end
                SQ_PLAN: begin
                    n_q        <= plan_n;
                    ctake_left <= plan_n;
                    chunk_left <= plan_n;
                    blk_q      <= plan_blk;
                    state      <= SQ_CLR;
                end
                SQ_CLR:     if (bc_done) state <= SQ_SETUP;
                SQ_SETUP:   if (bc_done) state <= SQ_COUNT;
                SQ_COUNT:   if (bc_done) state <= SQ_DATA;
                SQ_DATA: begin
                    if (pk_take) begin
                        ctake_left <= ctake_left - 1'b1;
                        pack_rem   <= pack_rem - 1'b1;
                    end
                    if (bc_done) begin
                        cur_addr   <= cur_addr + 1'b1;
                        chunk_left <= chunk_left - 1'b1;
                        if (chunk_left == NW'(1)) state <= SQ_CONFIRM;
                    end
                end
                SQ_CONFIRM: if (bc_done) state <= SQ_POLL;
                SQ_POLL:    if (bc_done) state <= SQ_CHECK;
                SQ_CHECK: begin
                    if (!st_ready)               state <= SQ_POLL;
                    else if (st_err) begin
                        err_q <= 1'b1;
                        state <= SQ_IDLE;
                    end
                    else if (pack_rem == '0)     state <= SQ_RDARR;
                    else                         state <= SQ_PLAN;
                end
                SQ_RDARR:   if (bc_done) state <= SQ_FIN;
                SQ_FIN:     state <= SQ_IDLE;
                default:    state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nbp_checker.sv
// Protocol checker for the sequencer's flash pins and job outputs.
// Assumes it is bound to nor_bufprog_seq and sees its pins only.
module nbp_checker #(
    parameter int CYC   = 20,
    parameter int WE_LO = 5,
    parameter int WE_HI = 15
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        we_n,
    input logic        oe_n,
    input logic        adv_n,
    input logic        dq_oe,
    input logic [24:0] addr,
    input logic [15:0] dq,
    input logic        done,
    input logic        error,
    input logic        s_ready
);
    logic [15:0] ce_run;
    logic [15:0] we_run;

    // Count of consecutive earlier clocks with the pin low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_run <= '0;
            we_run <= '0;
        end else begin
            ce_run <= ce_n ? 16'd0 : ce_run + 16'd1;
            we_run <= we_n ? 16'd0 : we_run + 16'd1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ce_n && we_n && oe_n && adv_n && !dq_oe && !done && !error && !s_ready));
    // R6
    we_inside_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ce_n && !adv_n && dq_oe && oe_n));
    // R7
    read_bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!dq_oe && we_n && !ce_n));
    // R12
    ce_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> (ce_run < 16'(CYC)));
    // R6
    we_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (we_run < 16'(WE_HI - WE_LO - 1)));
    // R6
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> ($stable(addr) && $stable(dq)));
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    error_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !done);

endmodule

bind nor_bufprog_seq nbp_checker #(.CYC(CYC), .WE_LO(WE_LO), .WE_HI(WE_HI)) u_nbp_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(flash_ce_n_o), .we_n(flash_we_n_o),
    .oe_n(flash_oe_n_o), .adv_n(flash_adv_n_o), .dq_oe(flash_dq_oe_o),
    .addr(flash_addr_o[24:0]), .dq(flash_dq_o), .done(done_o),
    .error(error_o), .s_ready(s_ready_o)
);

// File: tb/tb_nor_bufprog_seq.sv
`timescale 1ns/1ps
module tb_nor_bufprog_seq;
    localparam int AW = 25;
    localparam int LW = 12;
    localparam int CW = 8;
    localparam int BW = 16;
    localparam int CYC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [AW-1:0] base_addr_i = '0;
    logic [LW-1:0] byte_len_i = '0;
    logic [7:0] s_data_i = '0;
    logic s_valid_i = 1'b0;
    logic s_ready_o;
    logic [AW-1:0] flash_addr_o;
    logic [15:0] flash_dq_o, flash_dq_i;
    logic flash_dq_oe_o, flash_ce_n_o, flash_we_n_o, flash_oe_n_o, flash_adv_n_o;
    logic done_o, error_o;

    nor_bufprog_seq #(.ADDR_W(AW), .LEN_W(LW), .CHUNK_WORDS(CW), .BLOCK_WORDS(BW), .CYC(CYC)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .byte_len_i(byte_len_i), .s_data_i(s_data_i), .s_valid_i(s_valid_i),
        .s_ready_o(s_ready_o), .flash_addr_o(flash_addr_o), .flash_dq_o(flash_dq_o),
        .flash_dq_oe_o(flash_dq_oe_o), .flash_dq_i(flash_dq_i), .flash_ce_n_o(flash_ce_n_o),
        .flash_we_n_o(flash_we_n_o), .flash_oe_n_o(flash_oe_n_o), .flash_adv_n_o(flash_adv_n_o),
        .done_o(done_o), .error_o(error_o)
    );

    always #2.5 clk = ~clk;

    int vectors = 0;
    int fails = 0;

    logic [7:0]  bytes [0:599];
    int          exp_addr [0:1023];
    logic [15:0] exp_data [0:1023];
    int          exp_n, n_chunks, first_n;
    int          rec_addr [0:1023];
    logic [15:0] rec_data [0:1023];
    int          rec_n = 0;
    int          reads_total = 0, rd_in_chunk = 0;
    int          cur_bp = 0;
    bit          cur_inj = 1'b0;
    int          drv_i = 0, drv_len = 0, hs_cnt = 0;
    bit          drv_on = 1'b0, hs_q = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    // Expected write list per the command sequence requirements.
    function automatic void build_exp(input int base, input int len);
        int a, rem, bi, n, off, blk;
        logic [7:0] b0, b1;
        exp_n = 0; n_chunks = 0; first_n = 0;
        a = base; rem = (len + 1) / 2; bi = 0;
        while (rem > 0) begin
            off = a % BW; blk = a - off;
            n = CW;
            if (BW - off < n) n = BW - off;
            if (rem < n) n = rem;
            exp_addr[exp_n] = 0;   exp_data[exp_n] = 16'h0050; exp_n++;
            exp_addr[exp_n] = blk; exp_data[exp_n] = 16'h00E9; exp_n++;
            exp_addr[exp_n] = blk; exp_data[exp_n] = 16'(n - 1); exp_n++;
            for (int w = 0; w < n; w++) begin
                b0 = bytes[bi];
                b1 = (bi + 1 < len) ? bytes[bi + 1] : 8'hFF;
                exp_addr[exp_n] = a + w; exp_data[exp_n] = {rev8(b0), rev8(b1)}; exp_n++;
                bi += 2;
            end
            exp_addr[exp_n] = blk; exp_data[exp_n] = 16'h00D0; exp_n++;
            if (n_chunks == 0) first_n = n;
            n_chunks++; a += n; rem -= n;
        end
        exp_addr[exp_n] = 0; exp_data[exp_n] = 16'h00FF; exp_n++;
    endfunction

    // Stream source: byte handshakes decided away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            if (hs_q) begin drv_i++; hs_cnt++; end
            s_valid_i = drv_on && (drv_i < drv_len + 3) && ($urandom % 4 != 0);
            s_data_i  = bytes[drv_i];
            hs_q      = s_valid_i && s_ready_o;
            if (!drv_on && s_ready_o) chk(1'b0, "R13 ready outside job", 1, 0);
        end
    end

    // Flash model and pin timing monitor.
    initial begin
        int k, ce_run, we_len;
        bit prev_we, prev_oe, was_rd;
        ce_run = 0; we_len = 0; prev_we = 1'b1; prev_oe = 1'b1; was_rd = 1'b0;
        flash_dq_i = 16'h0000;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (!flash_ce_n_o) begin
                k = ce_run; ce_run++;
                if (k == 0) was_rd = !flash_oe_n_o;
            end else begin
                if (ce_run != 0)
                    chk(ce_run == CYC, was_rd ? "R7 read window" : "R6 write window", ce_run, CYC);
                ce_run = 0; k = -1;
            end
            if (!flash_we_n_o && prev_we) begin
                chk(k == 5, "R6 write-enable start", k, 5);
                chk(flash_dq_oe_o && !flash_adv_n_o, "R6 bus driven", flash_dq_oe_o, 1);
                rec_addr[rec_n] = int'(flash_addr_o); rec_data[rec_n] = flash_dq_o; rec_n++;
                if (flash_addr_o == '0 && flash_dq_o == 16'h0050) rd_in_chunk = 0;
            end
            if (!flash_we_n_o) we_len++;
            if (flash_we_n_o && !prev_we) begin
                chk(we_len == 9, "R6 write-enable length", we_len, 9);
                we_len = 0;
            end
            if (!flash_oe_n_o && prev_oe) begin
                reads_total++; rd_in_chunk++;
            end
            if (!flash_oe_n_o && k >= 15)
                flash_dq_i = (rd_in_chunk > cur_bp) ? (16'hA541 | 16'h0080 | (cur_inj ? 16'h0010 : 16'h0)) : 16'hA541;
            else
                flash_dq_i = 16'h0090;
            prev_we = flash_we_n_o; prev_oe = flash_oe_n_o;
        end
    end

    task automatic run_job(input int base, input int len, input int bp, input bit inj);
        int t; bit seen_done, seen_err; int lim;
        for (int i = 0; i < 600; i++) bytes[i] = 8'($urandom);
        build_exp(base, len);
        @(negedge clk); #1;
        rec_n = 0; reads_total = 0; rd_in_chunk = 0; cur_bp = bp; cur_inj = inj;
        drv_i = 0; drv_len = len; hs_cnt = 0; hs_q = 1'b0; drv_on = 1'b1;
        @(negedge clk);
        start_i = 1'b1; base_addr_i = AW'(base); byte_len_i = LW'(len);
        @(negedge clk);
        start_i = 1'b0;
        seen_done = 0; seen_err = 0; t = 0;
        while (!seen_done && !seen_err && t < 60000) begin
            @(negedge clk); t++;
            if (done_o) seen_done = 1;
            if (error_o) seen_err = 1;
        end
        if (inj) begin
            repeat (60) @(negedge clk);
            chk(seen_err && error_o, "R9 error flag", error_o, 1);
            chk(!seen_done, "R9 no done", seen_done, 0);
            lim = first_n + 4;
            chk(rec_n == lim, "R9 no writes after error", rec_n, lim);
            for (int i = 0; i < lim && i < rec_n; i++) begin
                chk(rec_addr[i] == exp_addr[i], "R2 address", rec_addr[i], exp_addr[i]);
                chk(rec_data[i] == exp_data[i], "R4 data", rec_data[i], exp_data[i]);
            end
            chk(reads_total == bp + 1, "R8 polls", reads_total, bp + 1);
        end else begin
            chk(seen_done, "R10 done seen", seen_done, 1);
            chk(!error_o, "R9 no error", error_o, 0);
            chk(rec_n == exp_n, "R3 write count", rec_n, exp_n);
            for (int i = 0; i < exp_n && i < rec_n; i++) begin
                chk(rec_addr[i] == exp_addr[i], (len == 0) ? "R11 address" : "R3 address", rec_addr[i], exp_addr[i]);
                chk(rec_data[i] == exp_data[i], (len % 2 == 1 && i == exp_n - 3) ? "R5 pad word" : "R2 data", rec_data[i], exp_data[i]);
            end
            chk(reads_total == n_chunks * (bp + 1), "R8 polls", reads_total, n_chunks * (bp + 1));
            chk(hs_cnt == len, "R13 bytes taken", hs_cnt, len);
            @(negedge clk);
            chk(!done_o, "R10 done one clock", done_o, 0);
        end
        drv_on = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20241));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(flash_ce_n_o && flash_we_n_o && flash_oe_n_o && flash_adv_n_o, "R1 strobes idle", {flash_ce_n_o, flash_we_n_o, flash_oe_n_o, flash_adv_n_o}, 4'hF);
        chk(!flash_dq_oe_o && !s_ready_o && !done_o && !error_o, "R1 outputs low", {flash_dq_oe_o, s_ready_o, done_o, error_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_job(0, 16, 0, 1'b0);    // R2 one aligned full chunk
        run_job(3, 7, 1, 1'b0);     // R5 odd length pad
        run_job(13, 20, 2, 1'b0);   // R3 block end cuts a chunk
        run_job(7, 0, 0, 1'b0);     // R11 empty job
        run_job(5, 10, 1, 1'b1);    // R9 status error
        run_job(30, 33, 0, 1'b0);   // recovery after error
        for (int j = 0; j < 14; j++)
            run_job(int'($urandom % 64), int'($urandom % 41), int'($urandom % 3), 1'b0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule